// File: doc/BRIEF.md
# I2C Converter Read Responder

This block acts as the bus-facing digital half of a 12-bit converter that sits on a two-wire serial bus as a target. It oversamples the clock and data lines with the system clock, finds START and STOP conditions, and collects the address byte that follows a START. The byte matches when its top four bits carry the fixed device code 1001, the next three equal the strapped `dev_sel` pins, and the final bit requests a read. On a match the block pulls the data line low for the acknowledge clock. It then streams the held 12-bit value as two bytes: the upper byte is four zero bits followed by bits 11..8, and the lower byte holds bits 7..0, most significant bit first.

The analog side is not modelled. The block fires a one-cycle `conv_start` pulse at each point where a real converter would begin sampling, and at that same pulse it copies `sample_in` into a holding register. The first pulse comes at the SCL falling edge that opens the acknowledge clock of a matched read. A later pulse comes at the falling edge that closes every lower-byte LSB. If the controller acknowledges the lower byte, the next upper byte carries the new value. A not-acknowledge ends streaming until the next bus condition. The data output is open-drain: `sda_pull` high means the block pulls SDA low.

Top module: `i2c_adc_responder`

## Requirements
- R1: After a START, an address byte equal to {1001, dev_sel[2:0], 1} (sent MSB first, last bit = read) is acknowledged by pulling SDA low for the whole ninth clock.
- R2: An address byte with another device code, other `dev_sel` bits, or the read bit 0 gets no acknowledge, and SDA stays released until the next START or STOP.
- R3: `conv_start` is a single system-clock pulse that follows the SCL falling edge opening the acknowledge clock of a matched read within four system clocks.
- R4: The first data byte is 0000 followed by bits 11..8 of the held value, and the second is bits 7..0, each sent MSB first with SDA changed only while SCL is low.
- R5: SDA is released during the ninth clock after every data byte, so a controller sending 1 reads 1.
- R6: A `conv_start` pulse also follows the falling edge that ends every lower-byte LSB. After a controller ACK (0) on that byte, the next upper and lower bytes carry the value captured at that pulse.
- R7: After a controller NAK (1) on any data byte, SDA stays released for all further clocks until a START or STOP.
- R8: The block never begins pulling SDA low while SCL is high.
- R9: A START seen mid-transfer restarts address reception. A STOP releases SDA and returns to idle, where clocks without a START are ignored.
- R10: Changes on `sample_in` between two `conv_start` pulses do not alter the bits being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| dev_sel | input | 3 | Strapped low address bits |
| sample_in | input | 12 | Parallel converter result |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| conv_start | output | 1 | One-cycle pulse where a conversion would begin |

## Verification
The hardest state to reach is a START or STOP placed inside a data byte. The controller can only make that edge on SDA when the responder has released the line, so the bench streams an all-ones value and breaks in during the lower byte, while every lower bit is released. Back-to-back reads are covered in the same way: a new value is presented just before each lower-byte LSB, and a different value is driven during shifting. The following upper byte must then show the captured value and not the value present on the port.

// File: rtl/i2c_adc_responder.sv
module i2c_adc_responder #(
  parameter logic [3:0] DEV_CODE = 4'b1001,
  parameter int         SYNC     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  dev_sel,
  input  logic [11:0] sample_in,
  output logic        sda_pull,
  output logic        conv_start
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_TX, S_MACK, S_NEXT, S_HOLD
  } st_t;

  logic [SYNC-1:0] scl_sync, sda_sync;
  logic            scl_d, sda_d;
  logic            scl_s, sda_s;
  logic            scl_rise, scl_fall, bus_start, bus_stop;

  st_t         state;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg;
  logic        hi_byte;
  logic [11:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_sync[SYNC-1];
  assign sda_s     = sda_sync[SYNC-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      hi_byte    <= 1'b0;
      held       <= '0;
      sda_pull   <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (bus_stop) begin
        state    <= S_IDLE;
        sda_pull <= 1'b0;
      end else if (bus_start) begin
        state    <= S_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (shreg == {DEV_CODE, dev_sel, 1'b1}) begin
                state      <= S_AACK;
                sda_pull   <= 1'b1;
                conv_start <= 1'b1;
                held       <= sample_in;
              end else begin
                state <= S_HOLD;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              shreg    <= {4'h0, held[11:8]};
              sda_pull <= 1'b1;
              hi_byte  <= 1'b1;
              bit_cnt  <= '0;
              state    <= S_TX;
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_pull <= 1'b0;
                state    <= S_MACK;
                if (!hi_byte) begin
                  conv_start <= 1'b1;
                  held       <= sample_in;
                end
              end else begin
                bit_cnt  <= bit_cnt + 4'd1;
                shreg    <= {shreg[6:0], 1'b0};
                sda_pull <= ~shreg[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) state <= sda_s ? S_HOLD : S_NEXT;
          end
          S_NEXT: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              hi_byte <= ~hi_byte;
              state   <= S_TX;
              if (hi_byte) begin
                shreg    <= held[7:0];
                sda_pull <= ~held[7];
              end else begin
                shreg    <= {4'h0, held[11:8]};
                sda_pull <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_ack_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_AACK) |-> sda_pull);

  assert_quiet_when_not_sending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR || state == S_HOLD || state == S_IDLE) |-> !sda_pull);

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_strobe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !scl_s);

  assert_release_for_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK) |-> !sda_pull);

  assert_pull_only_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  assert_stop_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (state == S_IDLE && !sda_pull));

  assert_capture_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (held == $past(sample_in)));

endmodule

// File: tb/test_i2c_adc_responder.sv
`timescale 1ns/1ps
module test_i2c_adc_responder;
  localparam int H = 8;
  localparam logic [11:0] JUNK = 12'h6C9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  pins = 3'b101;
  logic [11:0] sample = 12'h000;
  logic        sda_pull, conv_start;
  wire         bus = sda_m & ~sda_pull;

  int checks = 0, errors = 0, strobes = 0, exp_strobes = 0, since_fall = 0;
  logic scl_q = 1'b1, prev_strobe = 1'b0, prev_pull = 1'b0;

  always #2.5 clk = ~clk;

  i2c_adc_responder i_i2c_adc_responder (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus), .dev_sel(pins),
    .sample_in(sample), .sda_pull(sda_pull), .conv_start(conv_start));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (scl_q && !scl) since_fall <= 0; else since_fall <= since_fall + 1;
    scl_q <= scl;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_start) begin
        strobes++;
        chk(since_fall <= 4, "R3", "strobe delay after scl fall", since_fall, 4);
        chk(!prev_strobe, "R3", "strobe wider than one cycle", 1, 0);
      end
      if (sda_pull && !prev_pull)
        chk(!scl_q, "R8", "pull started while scl high", 1, 0);
    end
    prev_strobe = conv_start;
    prev_pull = sda_pull;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; idle(H);
    scl = 1'b1; idle(H);
    sda_m = 1'b0; idle(H);
    scl = 1'b0; idle(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; idle(H);
    scl = 1'b1; idle(H);
    sda_m = 1'b1; idle(H);
  endtask

  task automatic bit_x(input bit b, output bit r);
    sda_m = b; idle(H);
    scl = 1'b1; idle(H/2);
    r = bus; idle(H/2);
    scl = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) bit_x(v[i], r);
    bit_x(1'b1, ack);
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] v, output bit rel);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, r);
      v[i] = r;
    end
    bit_x(mack, rel);
  endtask

  task automatic stream(input int n, input logic [11:0] vals [4]);
    bit a, rel;
    logic [7:0] u, l, x;
    bus_start();
    sample = vals[0];
    wr_byte({4'b1001, pins, 1'b1}, a);
    exp_strobes++;
    sample = JUNK;
    chk(a == 1'b0, "R1", "address ack", a, 0);
    for (int k = 0; k < n; k++) begin
      rd_byte(1'b0, u, rel);
      chk(u == {4'h0, vals[k][11:8]}, k == 0 ? "R4/R10" : "R6/R10", "upper byte", u, {4'h0, vals[k][11:8]});
      if (k < n - 1) sample = vals[k+1];
      rd_byte(k == n - 1, l, rel);
      exp_strobes++;
      sample = JUNK;
      chk(l == vals[k][7:0], "R4", "lower byte", l, vals[k][7:0]);
      if (k == n - 1) chk(rel == 1'b1, "R5", "release on ninth clock", rel, 1);
    end
    rd_byte(1'b1, x, rel);
    chk(x == 8'hFF, "R7", "silent after NAK", x, 8'hFF);
    bus_stop();
    chk(strobes == exp_strobes, "R6", "strobe count", strobes, exp_strobes);
  endtask

  task automatic reject(input logic [7:0] addr);
    bit a, rel;
    logic [7:0] x;
    bus_start();
    wr_byte(addr, a);
    chk(a == 1'b1, "R2", "no ack on mismatch", a, 1);
    rd_byte(1'b1, x, rel);
    chk(x == 8'hFF && rel, "R2", "line released after mismatch", x, 8'hFF);
    bus_stop();
    chk(strobes == exp_strobes, "R2", "no strobe on mismatch", strobes, exp_strobes);
  endtask

  initial begin
    logic [11:0] v [4];
    logic [7:0] u, x;
    bit a, rel, r;

    idle(10);
    rst_n = 1'b1;
    idle(4);
    chk(sda_pull == 1'b0, "R9", "reset pull", sda_pull, 0);
    chk(conv_start == 1'b0, "R3", "reset strobe", conv_start, 0);

    v = '{12'hA5C, 12'h000, 12'h000, 12'h000};
    stream(1, v);
    v = '{12'h3E7, 12'hFFF, 12'h081, 12'h9B4};
    stream(4, v);

    reject({4'b1001, 3'b011, 1'b1});
    reject({4'b1001, pins, 1'b0});
    reject({4'b1011, pins, 1'b1});

    bus_start();
    sample = 12'h7D2;
    wr_byte({4'b1001, pins, 1'b1}, a);
    exp_strobes++;
    sample = JUNK;
    chk(a == 1'b0, "R1", "address ack", a, 0);
    rd_byte(1'b1, u, rel);
    chk(u == 8'h07, "R4", "upper byte", u, 8'h07);
    chk(rel == 1'b1, "R5", "release after upper byte", rel, 1);
    rd_byte(1'b1, x, rel);
    chk(x == 8'hFF, "R7", "silent after upper NAK", x, 8'hFF);
    bus_stop();

    bus_start();
    sample = 12'hFFF;
    wr_byte({4'b1001, pins, 1'b1}, a);
    exp_strobes++;
    rd_byte(1'b0, u, rel);
    chk(u == 8'h0F, "R4", "upper byte", u, 8'h0F);
    for (int i = 0; i < 3; i++) bit_x(1'b1, r);
    bus_start();
    sample = 12'h5A3;
    wr_byte({4'b1001, pins, 1'b1}, a);
    exp_strobes++;
    sample = JUNK;
    chk(a == 1'b0, "R9", "ack after repeated start", a, 0);
    rd_byte(1'b0, u, rel);
    chk(u == 8'h05, "R9", "upper after restart", u, 8'h05);
    rd_byte(1'b1, x, rel);
    exp_strobes++;
    chk(x == 8'hA3, "R9", "lower after restart", x, 8'hA3);
    bus_stop();

    bus_start();
    sample = 12'hFFF;
    wr_byte({4'b1001, pins, 1'b1}, a);
    exp_strobes++;
    rd_byte(1'b0, u, rel);
    for (int i = 0; i < 2; i++) bit_x(1'b1, r);
    bus_stop();
    idle(4);
    chk(sda_pull == 1'b0, "R9", "released after stop", sda_pull, 0);
    scl = 1'b0; idle(H);
    wr_byte({4'b1001, pins, 1'b1}, a);
    chk(a == 1'b1, "R9", "idle ignores clocks", a, 1);
    scl = 1'b1; idle(H);
    chk(strobes == exp_strobes, "R9", "strobe count", strobes, exp_strobes);

    v = '{12'h1F0, 12'h80F, 12'h000, 12'h000};
    stream(2, v);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule